// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave-side protocol engine for a 2048-byte serial memory on a two-wire bus. The raw clock and data lines come in from the pads. The block resynchronises them to a fast system clock and filters out short glitches. From the clean lines it recognises start and stop conditions and shifts bytes in and out. The only bus output is an enable that pulls the shared data line low.

Every transfer opens with a control byte. The top four bits must carry the device code `1010`. The next three bits give the upper address bits, and the last bit picks the direction: 1 reads, 0 writes. A write then takes one word-address byte followed by any number of data bytes. Each data byte goes to a page-write controller as a single-cycle request. A commit pulse follows the closing stop condition.

Reads fetch bytes through a simple combinational memory read port, addressed by the engine's internal pointer. The engine supports current-address, random and sequential reads. While the page-write controller reports a write cycle in progress, the engine acknowledges nothing. A master can therefore poll for the end of the write.

Top module: `twm_slave_engine`

## Requirements
- R1: A falling data line while the clock is high is a START and restarts control-byte reception from any state. A rising data line while the clock is high is a STOP and returns the engine to idle from any state, including partway through a byte.
- R2: The control byte is received most significant bit first. The engine acknowledges it only when bits 7:4 equal `1010`. On a mismatch, no byte is acknowledged until the next START.
- R3: An acknowledge holds `sda_oe` high through the whole high phase of the ninth clock. `sda_oe` changes only after a filtered clock falling edge or a START/STOP, and it is low after reset.
- R4: Each acknowledged data byte of a write produces a one-cycle `wr_valid`. Its address is the control byte's bits 3:1 (address bits 10:8) joined with the word-address byte (bits 7:0). `wr_commit` pulses once after a STOP that follows at least one data byte.
- R5: During a write, only the low 4 pointer bits step after each data byte, wrapping within the 16-byte page. The upper 7 bits stay fixed.
- R6: While `busy` is high, no byte is acknowledged, including a valid control byte.
- R7: A repeated START after the word-address acknowledge keeps the loaded pointer. A following read control byte returns the byte at that address.
- R8: A read with no address phase returns data from the last accessed address plus one. Address bits 10:8 come from the read control byte.
- R9: After each byte sent, the pointer steps by one over the full 11-bit range, wrapping from 0x7FF to 0x000. A master acknowledge (data line low in the ninth clock) starts the next byte.
- R10: After a master not-acknowledge (data line high in the ninth clock), the engine leaves the data line released for every further clock until a START or STOP.
- R11: A pulse on either line shorter than `FILT_LEN` system clocks has no effect on the protocol.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy | input | 1 | Write cycle in progress in the page-write controller |
| mem_rd_addr | output | ADDR_W | Read address (current pointer) |
| mem_rd_data | input | 8 | Memory byte at `mem_rd_addr` |
| wr_valid | output | 1 | One-cycle write request per data byte |
| wr_addr | output | ADDR_W | Address of the write request |
| wr_data | output | 8 | Data of the write request |
| wr_commit | output | 1 | One-cycle pulse: the write transfer ended with STOP |

## Verification
The bench builds the engine with its defaults: an 11-bit address, a 4-bit page field and a three-cycle glitch filter. The 11-bit pointer means a sequential read started at 0x7FE crosses the top of memory within three bytes, so the wrap to 0x000 is observed directly. The 4-bit page field makes the in-page rollover appear after sixteen bytes, so a seventeen-byte write shows both the wrap and the reuse of the first slot. A three-cycle filter lets a two-cycle pulse be injected on the data line during a clock-high phase, where it would otherwise read as a START.

// File: rtl/twm_pkg.sv
package twm_pkg;

    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         BYTE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_WAIT
    } eng_state_t;

    // Bus events derived from the filtered lines
    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    // Layout of the first byte after a START
    typedef struct packed {
        logic [3:0] code;
        logic [2:0] blk;
        logic       rd;
    } ctrl_byte_t;

    function automatic logic code_match(input ctrl_byte_t cb);
        return cb.code == DEV_CODE;
    endfunction

endpackage

// File: rtl/twm_line_cond.sv
module twm_line_cond #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_q
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            if (sync_q[1] == line_q) begin
                cnt_q <= '0;
            end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                line_q <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // A filtered change needs the new level held on the synchronised line
    assert_filter_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_q) |-> ($past(sync_q[1], 1) == line_q) && ($past(sync_q[1], 2) == line_q));

endmodule

// File: rtl/twm_bus_events.sv
module twm_bus_events
    import twm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
        evt.stop  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;
        evt.rise  = scl_f & ~scl_prev_q;
        evt.fall  = ~scl_f & scl_prev_q;
        evt.sda   = sda_f;
    end

endmodule

// File: rtl/twm_proto_fsm.sv
module twm_proto_fsm
    import twm_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic              busy,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit
);
    localparam int BLK_W = ADDR_W - BYTE_W;

    eng_state_t        state_q;
    logic [3:0]        bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              sda_oe_q;
    logic              rd_mode_q;
    logic              m_ack_q;
    logic              wr_pend_q;
    logic              wr_valid_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [BYTE_W-1:0] wr_data_q;
    logic              wr_commit_q;

    ctrl_byte_t        cb;
    logic [ADDR_W-1:0] ptr_seq_nx;
    logic [ADDR_W-1:0] ptr_page_nx;
    logic              rx_state;

    assign cb          = ctrl_byte_t'(shreg_q);
    assign ptr_seq_nx  = ptr_q + ADDR_W'(1);
    assign ptr_page_nx = {ptr_q[ADDR_W-1:PAGE_W], ptr_q[PAGE_W-1:0] + PAGE_W'(1)};
    assign rx_state    = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            bit_cnt_q   <= '0;
            shreg_q     <= '0;
            ptr_q       <= '0;
            sda_oe_q    <= 1'b0;
            rd_mode_q   <= 1'b0;
            m_ack_q     <= 1'b0;
            wr_pend_q   <= 1'b0;
            wr_valid_q  <= 1'b0;
            wr_addr_q   <= '0;
            wr_data_q   <= '0;
            wr_commit_q <= 1'b0;
        end else begin
            wr_valid_q  <= 1'b0;
            wr_commit_q <= 1'b0;
            if (evt.stop) begin
                state_q     <= ST_IDLE;
                sda_oe_q    <= 1'b0;
                bit_cnt_q   <= '0;
                wr_commit_q <= wr_pend_q;
                wr_pend_q   <= 1'b0;
            end else if (evt.start) begin
                state_q   <= ST_CTRL;
                sda_oe_q  <= 1'b0;
                bit_cnt_q <= '0;
                wr_pend_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE, ST_WAIT: ;
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (evt.rise && bit_cnt_q < 4'd8) begin
                            shreg_q   <= {shreg_q[BYTE_W-2:0], evt.sda};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end else if (evt.fall && bit_cnt_q == 4'd8) begin
                            // byte complete: decide on the acknowledge
                            bit_cnt_q <= 4'd9;
                            if (busy) begin
                                state_q <= ST_WAIT;
                            end else if (state_q == ST_CTRL) begin
                                if (code_match(cb)) begin
                                    sda_oe_q                   <= 1'b1;
                                    ptr_q[ADDR_W-1:BYTE_W]     <= cb.blk[BLK_W-1:0];
                                    rd_mode_q                  <= cb.rd;
                                end else begin
                                    state_q <= ST_WAIT;
                                end
                            end else if (state_q == ST_ADDR) begin
                                sda_oe_q            <= 1'b1;
                                ptr_q[BYTE_W-1:0]   <= shreg_q;
                            end else begin
                                sda_oe_q   <= 1'b1;
                                wr_valid_q <= 1'b1;
                                wr_addr_q  <= ptr_q;
                                wr_data_q  <= shreg_q;
                                wr_pend_q  <= 1'b1;
                                ptr_q      <= ptr_page_nx;
                            end
                        end else if (evt.fall && bit_cnt_q == 4'd9) begin
                            // end of the acknowledge slot
                            sda_oe_q  <= 1'b0;
                            bit_cnt_q <= '0;
                            if (state_q == ST_CTRL) begin
                                if (rd_mode_q) begin
                                    state_q   <= ST_RDATA;
                                    shreg_q   <= {mem_rd_data[BYTE_W-2:0], 1'b0};
                                    sda_oe_q  <= ~mem_rd_data[BYTE_W-1];
                                    bit_cnt_q <= 4'd1;
                                end else begin
                                    state_q <= ST_ADDR;
                                end
                            end else begin
                                state_q <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (evt.fall) begin
                            if (bit_cnt_q < 4'd8) begin
                                sda_oe_q  <= ~shreg_q[BYTE_W-1];
                                shreg_q   <= {shreg_q[BYTE_W-2:0], 1'b0};
                                bit_cnt_q <= bit_cnt_q + 4'd1;
                            end else begin
                                sda_oe_q  <= 1'b0;
                                ptr_q     <= ptr_seq_nx;
                                bit_cnt_q <= '0;
                                state_q   <= ST_RACK;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            m_ack_q <= ~evt.sda;
                        end else if (evt.fall) begin
                            if (m_ack_q) begin
                                state_q   <= ST_RDATA;
                                shreg_q   <= {mem_rd_data[BYTE_W-2:0], 1'b0};
                                sda_oe_q  <= ~mem_rd_data[BYTE_W-1];
                                bit_cnt_q <= 4'd1;
                            end else begin
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe    = sda_oe_q;
    assign ptr_o     = ptr_q;
    assign wr_valid  = wr_valid_q;
    assign wr_addr   = wr_addr_q;
    assign wr_data   = wr_data_q;
    assign wr_commit = wr_commit_q;

    assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_q) |-> $past(evt.fall || evt.start || evt.stop));

    assert_busy_no_ack_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_state && evt.fall && bit_cnt_q == 4'd8 && busy) |=> !sda_oe_q);

    assert_commit_after_stop_R4: assert property (@(posedge clk) disable iff (rst)
        wr_commit_q |-> $past(evt.stop));

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (rst)
        wr_valid_q |=> !wr_valid_q);

    assert_wait_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) |-> !sda_oe_q);

    assert_read_step_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_RDATA && state_q == ST_RACK) |-> ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1)));

endmodule

// File: rtl/twm_slave_engine.sv
module twm_slave_engine
    import twm_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 4,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              busy,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int N_LINES = 2;
    localparam int IDX_SCL = 1;
    localparam int IDX_SDA = 0;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    bus_evt_t           evt;

    assign raw_lines = {scl_in, sda_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        twm_line_cond #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk     (clk),
            .rst     (rst),
            .line_in (raw_lines[g]),
            .line_q  (filt_lines[g])
        );
    end

    twm_bus_events u_evt (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[IDX_SCL]),
        .sda_f (filt_lines[IDX_SDA]),
        .evt   (evt)
    );

    twm_proto_fsm #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .busy        (busy),
        .mem_rd_data (mem_rd_data),
        .sda_oe      (sda_oe),
        .ptr_o       (mem_rd_addr),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_commit   (wr_commit)
    );

endmodule

// File: tb/twm_slave_engine_tb.sv
module twm_slave_engine_tb_top;
    localparam int Q  = 10;
    localparam int WD = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy_b = 1'b0;
    logic        sda_oe;
    logic        sda_w;
    logic [10:0] mem_rd_addr;
    logic [7:0]  mem_rd_data;
    logic        wr_valid;
    logic [10:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_commit;

    int n_chk = 0;
    int n_err = 0;
    int wr_n = 0;
    int commit_n = 0;
    logic [10:0] wa [32];
    logic [7:0]  wd [32];

    always #5 clk = ~clk;

    assign sda_w = sda_m & ~sda_oe;

    function automatic logic [7:0] pat(input logic [10:0] a);
        int t;
        t = int'(a) * 29 + 7;
        return t[7:0];
    endfunction

    assign mem_rd_data = pat(mem_rd_addr);

    twm_slave_engine dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_w), .sda_oe(sda_oe),
        .busy(busy_b), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    always @(negedge clk) begin
        if (wr_valid) begin
            if (wr_n < 32) begin
                wa[wr_n] = wr_addr;
                wd[wr_n] = wr_data;
            end
            wr_n++;
        end
        if (wr_commit) commit_n++;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cbyte(input logic [2:0] blk, input logic rd);
        return {4'b1010, blk, rd};
    endfunction

    task automatic start_c();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        sda_m = 1'b0; wq(2 * Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(2 * Q);
        sda_m = 1'b1; wq(2 * Q);
    endtask

    // one clock: line is high unless the data line stayed low across the high phase
    task automatic clk_bit(input logic b, input logic glitch, output logic line);
        logic s1, s2;
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2);
        s1 = sda_w;
        if (glitch) begin
            wq(5); sda_m = ~b; wq(2); sda_m = b; wq(2 * Q - 10);
        end else begin
            wq(2 * Q - 3);
        end
        s2 = sda_w; wq(1);
        scl_m = 1'b0; wq(Q);
        line = s1 | s2;
    endtask

    task automatic write_byte(input logic [7:0] b, input int gl_idx, output logic acked);
        logic l;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], i == gl_idx, l);
        clk_bit(1'b1, 1'b0, l);
        acked = ~l;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] d);
        logic l;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, l);
            d[i] = l;
        end
        clk_bit(~m_ack, 1'b0, l);
    endtask

    task automatic test_reset();
        wq(3);
        chk("R3", "sda_oe after reset", int'(sda_oe), 0);
        chk("R4", "wr_valid after reset", int'(wr_valid), 0);
        chk("R4", "wr_commit after reset", int'(wr_commit), 0);
    endtask

    task automatic test_byte_write();
        logic a; int base, cbase;
        base = wr_n; cbase = commit_n;
        start_c();
        write_byte(cbyte(3'd3, 1'b0), -1, a); chk("R2", "ctrl ack", int'(a), 1);
        write_byte(8'h5C, -1, a);             chk("R3", "addr ack", int'(a), 1);
        write_byte(8'h3D, -1, a);             chk("R3", "data ack", int'(a), 1);
        chk("R4", "no commit before stop", commit_n - cbase, 0);
        stop_c(); wq(20);
        chk("R4", "write count", wr_n - base, 1);
        chk("R4", "write addr", int'(wa[base]), 'h35C);
        chk("R4", "write data", int'(wd[base]), 'h3D);
        chk("R4", "commit count", commit_n - cbase, 1);
    endtask

    task automatic test_bad_code();
        logic a; int base, cbase;
        base = wr_n; cbase = commit_n;
        start_c();
        write_byte(8'hB0, -1, a); chk("R2", "bad code no ack", int'(a), 0);
        write_byte(8'h12, -1, a); chk("R2", "addr after bad code no ack", int'(a), 0);
        write_byte(8'h34, -1, a); chk("R2", "data after bad code no ack", int'(a), 0);
        stop_c(); wq(20);
        chk("R2", "no write request", wr_n - base, 0);
        chk("R2", "no commit", commit_n - cbase, 0);
    endtask

    task automatic test_page_wrap();
        logic a; int base, cbase, okc;
        base = wr_n; cbase = commit_n; okc = 0;
        start_c();
        write_byte(cbyte(3'd1, 1'b0), -1, a);
        write_byte(8'hFE, -1, a);
        for (int i = 0; i < 17; i++) begin
            write_byte(8'(8'h40 + i), -1, a);
            okc += int'(a);
        end
        stop_c(); wq(20);
        chk("R5", "page acks", okc, 17);
        chk("R5", "page count", wr_n - base, 17);
        for (int i = 0; i < 17; i++) begin
            chk("R5", "page addr", int'(wa[base + i]), 'h1F0 | ((14 + i) & 15));
            chk("R5", "page data", int'(wd[base + i]), 'h40 + i);
        end
        chk("R4", "page commit", commit_n - cbase, 1);
    endtask

    task automatic test_busy_poll();
        logic a;
        busy_b = 1'b1;
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a); chk("R6", "write ctrl while busy", int'(a), 0);
        stop_c();
        start_c();
        write_byte(cbyte(3'd2, 1'b1), -1, a); chk("R6", "read ctrl while busy", int'(a), 0);
        stop_c();
        busy_b = 1'b0;
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a); chk("R6", "ctrl after busy", int'(a), 1);
        stop_c();
    endtask

    task automatic test_random_read();
        logic a; logic [7:0] d;
        start_c();
        write_byte(cbyte(3'd2, 1'b0), -1, a);
        write_byte(8'hA5, -1, a);
        start_c();
        write_byte(cbyte(3'd2, 1'b1), -1, a); chk("R7", "read ctrl ack", int'(a), 1);
        read_byte(1'b0, d);                   chk("R7", "random data", int'(d), int'(pat(11'h2A5)));
        stop_c();
    endtask

    task automatic test_current_read();
        logic a; logic [7:0] d;
        start_c();
        write_byte(cbyte(3'd2, 1'b1), -1, a); chk("R8", "current ctrl ack", int'(a), 1);
        read_byte(1'b0, d);                   chk("R8", "current data", int'(d), int'(pat(11'h2A6)));
        stop_c();
    endtask

    task automatic test_seq_wrap();
        logic a; logic [7:0] d;
        start_c();
        write_byte(cbyte(3'd7, 1'b0), -1, a);
        write_byte(8'hFE, -1, a);
        start_c();
        write_byte(cbyte(3'd7, 1'b1), -1, a);
        read_byte(1'b1, d); chk("R9", "seq byte 0", int'(d), int'(pat(11'h7FE)));
        read_byte(1'b1, d); chk("R9", "seq byte 1", int'(d), int'(pat(11'h7FF)));
        read_byte(1'b0, d); chk("R9", "seq byte wrap", int'(d), int'(pat(11'h000)));
        stop_c();
    endtask

    task automatic test_nack_quiet();
        logic a, l; logic [7:0] d; int highs;
        start_c();
        write_byte(cbyte(3'd3, 1'b1), -1, a);
        read_byte(1'b0, d); chk("R8", "current after wrap", int'(d), int'(pat(11'h301)));
        highs = 0;
        for (int i = 0; i < 9; i++) begin
            clk_bit(1'b1, 1'b0, l);
            highs += int'(l);
        end
        chk("R10", "released after nack", highs, 9);
        stop_c();
    endtask

    task automatic test_abort_recovery();
        logic a, l; int base, cbase;
        base = wr_n; cbase = commit_n;
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a);
        for (int i = 0; i < 3; i++) clk_bit(1'b1, 1'b0, l);
        stop_c();
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a); chk("R1", "ctrl after mid-byte stop", int'(a), 1);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, 1'b0, l);
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a); chk("R1", "ctrl after mid-byte start", int'(a), 1);
        stop_c(); wq(20);
        chk("R1", "no stray write", wr_n - base, 0);
        chk("R1", "no stray commit", commit_n - cbase, 0);
    endtask

    task automatic test_glitch();
        logic a; int base, cbase;
        base = wr_n; cbase = commit_n;
        start_c();
        write_byte(cbyte(3'd0, 1'b0), -1, a);
        write_byte(8'h10, -1, a);
        write_byte(8'h96, 2, a); chk("R11", "ack despite glitch", int'(a), 1);
        stop_c(); wq(20);
        chk("R11", "glitch write count", wr_n - base, 1);
        chk("R11", "glitch write addr", int'(wa[base]), 'h010);
        chk("R11", "glitch write data", int'(wd[base]), 'h96);
        chk("R11", "glitch commit", commit_n - cbase, 1);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_byte_write();
        test_bad_code();
        test_page_wrap();
        test_busy_poll();
        test_random_read();
        test_current_read();
        test_seq_wrap();
        test_nack_quiet();
        test_abort_recovery();
        test_glitch();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R1 watchdog actual=%0d expected=%0d", WD, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule